// File: doc/BRIEF.md
# Dual-Channel Converter Code Latch with Staged Low Byte

This block takes byte-wide writes from a host bus and turns them into two 12-bit codes for a pair of digital-to-analog converters. Each channel has two write offsets. One offset is for the low byte and one is for the high nibble. A low-byte write only fills a hidden staging register. A high-nibble write moves the new nibble and the staged byte into the channel's output latch in the same cycle. The converter therefore never sees a half-updated code when the host writes the low byte first.

If the host writes the high nibble first, the latch combines that nibble with whatever low byte was staged earlier. The output then holds a torn value until the next high-nibble write. Each channel also raises a one-cycle pulse when its latch has just loaded, so downstream logic knows a new code is present.

The write port is a single-cycle strobe with an address and a data byte. It has no back-pressure: every cycle with the strobe high is accepted as exactly one write. A host that needs flow control must hold off its own strobe.

Top module: `dac_pair_latch`

## Requirements
- R1: While reset (rst_n low) is asserted, both staging registers and both output codes are zero and both update pulses are low. The first high-nibble write after reset therefore combines with a low byte of 0x00.
- R2: A strobed write to a channel's low-byte offset changes neither code output and raises no update pulse.
- R3: A strobed write to a channel's high-nibble offset loads that channel's code with {wr_data[3:0], staged low byte}. The new code is visible in the cycle after the strobe.
- R4: Bits 7..4 of a high-nibble write have no effect on the loaded code.
- R5: If a high-nibble write comes before the matching low-byte write, the code takes the previously staged low byte. A later low-byte write stays invisible until the next high-nibble write.
- R6: A write to offsets 0 to 3, or any cycle with wr_en low, changes neither code and raises no pulse.
- R7: A channel's update pulse is high for exactly the one cycle after each strobe to its high-nibble offset, and is low at all other times.
- R8: The offsets (3-bit, base-relative) are fixed: 4 is channel 0 low byte, 5 is channel 0 high nibble, 6 is channel 1 low byte, and 7 is channel 1 high nibble. A write to one channel never changes the other channel's staging register, code or pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; one write per cycle high |
| wr_addr | input | 3 | Base-relative write offset |
| wr_data | input | 8 | Write data byte |
| code_ch0 | output | 12 | Latched converter code, channel 0 |
| code_ch1 | output | 12 | Latched converter code, channel 1 |
| upd_ch0 | output | 1 | One-cycle pulse after channel 0 code loads |
| upd_ch1 | output | 1 | One-cycle pulse after channel 1 code loads |

## Verification
The hardest state to reach from the ports is a torn code. In that state, the staging register holds a byte that never reached the output, or the output holds a byte that the staging register has since replaced. The stimulus table reaches it by writing a high nibble before its low byte. It then writes a fresh low byte and checks that the code keeps the torn value until a second high-nibble write exposes the new byte. A directed test applies reset after a low-byte write and before the high-nibble write. It then shows that the staged byte was cleared by writing only a high nibble afterwards.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
  localparam int NUM_CH   = 2;
  localparam int ADDR_W   = 3;
  localparam int BYTE_W   = 8;
  localparam int HI_W     = 4;
  localparam int CODE_W   = BYTE_W + HI_W;
  localparam int BASE_OFF = 4;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode #(
  parameter int ADDR_W   = 3,
  parameter int NUM_CH   = 2,
  parameter int BASE_OFF = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    localparam int LO_OFF = BASE_OFF + 2 * n;
    localparam int HI_OFF = LO_OFF + 1;
    always_comb begin
      lo_we[n] = wr_en && (wr_addr == ADDR_W'(LO_OFF));
      hi_we[n] = wr_en && (wr_addr == ADDR_W'(HI_OFF));
    end
  end
endmodule

// File: rtl/dac_chan_buf.sv
module dac_chan_buf #(
  parameter int BYTE_W = 8,
  parameter int HI_W   = 4,
  localparam int CODE_W = BYTE_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CODE_W-1:0] code,
  output logic              upd
);
  logic [BYTE_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      code    <= '0;
      upd     <= 1'b0;
    end else begin
      upd <= hi_we;
      if (lo_we) stage_q <= wr_data;
      if (hi_we) code <= {wr_data[HI_W-1:0], stage_q};
    end
  end
endmodule

// File: rtl/dac_pair_latch.sv
module dac_pair_latch
  import dac_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CODE_W-1:0] code_ch0,
  output logic [CODE_W-1:0] code_ch1,
  output logic              upd_ch0,
  output logic              upd_ch1
);
  logic [NUM_CH-1:0] lo_we, hi_we, upd_w;
  code_t             code_w [NUM_CH];

  dac_wr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE_OFF(BASE_OFF)) dec_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .lo_we(lo_we), .hi_we(hi_we)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dac_chan_buf #(.BYTE_W(BYTE_W), .HI_W(HI_W)) buf_i (
      .clk(clk), .rst_n(rst_n), .lo_we(lo_we[n]), .hi_we(hi_we[n]),
      .wr_data(wr_data), .code(code_w[n]), .upd(upd_w[n])
    );
  end

  assign code_ch0 = code_w[0];
  assign code_ch1 = code_w[1];
  assign upd_ch0  = upd_w[0];
  assign upd_ch1  = upd_w[1];
endmodule

// File: rtl/dac_pair_latch_chk.sv
module dac_pair_latch_chk
  import dac_latch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [CODE_W-1:0] code_ch0,
  input logic [CODE_W-1:0] code_ch1,
  input logic              upd_ch0,
  input logic              upd_ch1
);
  logic hit0_lo, hit0_hi, hit1_lo, hit1_hi, any_hit;
  assign hit0_lo = wr_en && wr_addr == 3'd4;
  assign hit0_hi = wr_en && wr_addr == 3'd5;
  assign hit1_lo = wr_en && wr_addr == 3'd6;
  assign hit1_hi = wr_en && wr_addr == 3'd7;
  assign any_hit = hit0_lo || hit0_hi || hit1_lo || hit1_hi;

  // R2
  p_lo_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0_lo || hit1_lo) |=> ($stable(code_ch0) && $stable(code_ch1) && !upd_ch0 && !upd_ch1));
  // R3
  p_hi_load_ch0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit0_hi |=> (code_ch0[11:8] == $past(wr_data[3:0])));
  p_hi_load_ch1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit1_hi |=> (code_ch1[11:8] == $past(wr_data[3:0])));
  // R6
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |=> ($stable(code_ch0) && $stable(code_ch1) && !upd_ch0 && !upd_ch1));
  // R7
  p_pulse_src_ch0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_ch0) |-> $past(hit0_hi));
  p_pulse_src_ch1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_ch1) |-> $past(hit1_hi));
  // R8
  p_isolate_ch1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0_lo || hit0_hi) |=> ($stable(code_ch1) && !upd_ch1));
  p_isolate_ch0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1_lo || hit1_hi) |=> ($stable(code_ch0) && !upd_ch0));
endmodule

bind dac_pair_latch dac_pair_latch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .code_ch0(code_ch0), .code_ch1(code_ch1), .upd_ch0(upd_ch0), .upd_ch1(upd_ch1)
);

// File: tb/dac_pair_latch_tb.sv
`timescale 1ns/1ps
module dac_pair_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] code_ch0, code_ch1;
  logic        upd_ch0, upd_ch1;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_pair_latch dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .code_ch0(code_ch0), .code_ch1(code_ch1), .upd_ch0(upd_ch0), .upd_ch1(upd_ch1)
  );

  // {addr, data, exp code0, exp code1, exp {upd1,upd0}}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {3'd4, 8'hA5, 12'h000, 12'h000, 2'b00},  // R2 low only
    {3'd5, 8'hF3, 12'h3A5, 12'h000, 2'b01},  // R3 R4 load, top bits dropped
    {3'd6, 8'h3C, 12'h3A5, 12'h000, 2'b00},  // R8 ch1 low
    {3'd7, 8'h07, 12'h3A5, 12'h73C, 2'b10},  // R8 ch1 load
    {3'd5, 8'h0C, 12'hCA5, 12'h73C, 2'b01},  // R5 high first torn
    {3'd4, 8'h11, 12'hCA5, 12'h73C, 2'b00},  // R5 late low hidden
    {3'd5, 8'h0C, 12'hC11, 12'h73C, 2'b01},  // R5 second high exposes
    {3'd0, 8'hFF, 12'hC11, 12'h73C, 2'b00},  // R6
    {3'd3, 8'hFF, 12'hC11, 12'h73C, 2'b00},  // R6
    {3'd1, 8'h5A, 12'hC11, 12'h73C, 2'b00},  // R6
    {3'd7, 8'hFE, 12'hC11, 12'hE3C, 2'b10},  // R4 upper nibble ignored
    {3'd6, 8'h00, 12'hC11, 12'hE3C, 2'b00},  // R2
    {3'd2, 8'h77, 12'hC11, 12'hE3C, 2'b00},  // R6
    {3'd7, 8'h00, 12'hC11, 12'h000, 2'b10}   // R3 R8
  };

  task automatic check(string req, logic [11:0] e0, logic [11:0] e1, logic [1:0] eu);
    checks++;
    if (code_ch0 !== e0 || code_ch1 !== e1 || {upd_ch1, upd_ch0} !== eu) begin
      failures++;
      $display("FAIL %s: got c0=%h c1=%h upd=%b, expected c0=%h c1=%h upd=%b",
               req, code_ch0, code_ch1, {upd_ch1, upd_ch0}, e0, e1, eu);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 12'h000, 12'h000, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][36:34], VEC[i][33:26]);
      check($sformatf("R2-R8 vector %0d", i), VEC[i][25:14], VEC[i][13:2], VEC[i][1:0]);
    end
    @(negedge clk);
    check("R7 pulse lasts one cycle", 12'hC11, 12'h000, 2'b00);
    wr_addr = 3'd5; wr_data = 8'h0F;
    @(negedge clk);
    check("R6 strobe low ignored", 12'hC11, 12'h000, 2'b00);
    wr(3'd4, 8'hEE);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid sequence", 12'h000, 12'h000, 2'b00);
    rst_n = 1'b1;
    wr(3'd5, 8'h09);
    check("R1 staging cleared by reset", 12'h900, 12'h000, 2'b01);
    wr(3'd5, 8'h02);
    check("R7 back-to-back pulse", 12'h200, 12'h000, 2'b01);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule